// File: doc/BRIEF.md
# Link Input Stop and Trigger Inhibit Controller

This block decides when the front-end data link must stop sending, and when the upstream trigger must be held off. It watches the number of free buffer pages left and the half-full flag of the input FIFO. It also obeys control bits written by software. Any of three causes can raise the link stop. The first is a low free-page count. The second is the input FIFO half-full flag, which software can enable or mask. The third is a force bit set by software. The trigger inhibit has its own free-page threshold, set apart from the stop threshold.

Each free-page comparison uses hysteresis. The output asserts once the count falls to the low mark or below it. It drops again only when the count rises above the low mark plus a programmable margin. Every output is registered. After reset a hold bit keeps the link stopped until software has set up the thresholds and cleared it. A small register port holds the thresholds and control bits, and a read-only status word shows which cause is active and the current free-page count.

Top module: `ingress_stop_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `link_stop` is 1 and `trig_inhibit` is 0. After reset the defaults are: control word 1 (hold set), stop low mark 16, stop margin 8, inhibit low mark 8, inhibit margin 4.
- R2: The control register is at address 0. While its bit 0 (hold) is 1, `link_stop` is 1 whatever the other inputs are. Once hold is cleared and no other cause is active, `link_stop` is 0 two clock edges later.
- R3: When `free_cnt` is at or below the stop low mark (address 1), `link_stop` is 1 two clock edges after `free_cnt` is applied.
- R4: Once the free-page stop cause is active, it stays active while `free_cnt` is at or below the low mark plus the stop margin (address 2). It clears two edges after `free_cnt` rises above that sum.
- R5: With control bit 2 (half-full enable) set, `infifo_half` = 1 makes `link_stop` 1 two edges later. With bit 2 clear, `infifo_half` has no effect.
- R6: Control bit 1 (force) makes `link_stop` 1 two edges after it is written, whatever `free_cnt` is.
- R7: `trig_inhibit` follows its own hysteresis. It asserts at or below the inhibit low mark (address 3) and releases above that mark plus the inhibit margin (address 4), with a latency of two edges. Hold, force, half-full and the stop thresholds do not affect it.
- R8: The status word is at address 5. Bit 0 is the free-page stop cause, bit 1 is the enabled half-full cause, bit 2 is force, bit 3 is hold, bit 4 is the inhibit state, bits 7:5 are zero, and bits 8 and up hold `free_cnt`.
- R9: A read returns the addressed register on `reg_rdata` one edge after `reg_addr` is presented. Addresses 6 and 7 read as zero, and a write to address 5 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| free_cnt | input | CNT_W | Current number of free buffer pages |
| infifo_half | input | 1 | Input FIFO half-full flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| link_stop | output | 1 | Stop request to the data link |
| trig_inhibit | output | 1 | Inhibit to the upstream trigger |

## Verification
The assertions assume that `free_cnt` and `infifo_half` are synchronous to `clk`. They also assume that the thresholds plus margins fit within the 33-bit sum used by the comparator. The hysteresis checks compare each edge of a cause with the count and thresholds one cycle earlier, so they also assume that registers are not rewritten in the same cycle as a crossing they are meant to judge. The stimulus drives every input at the falling edge. It writes thresholds only while `free_cnt` is held steady, and it steps the count through values on both sides of each low mark and each release point.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;
  typedef enum logic [2:0] {
    ADR_CTRL     = 3'd0,
    ADR_STOP_LO  = 3'd1,
    ADR_STOP_MRG = 3'd2,
    ADR_INH_LO   = 3'd3,
    ADR_INH_MRG  = 3'd4,
    ADR_STATUS   = 3'd5
  } stopctl_addr_e;

  localparam int CTL_HOLD_BIT  = 0;
  localparam int CTL_FORCE_BIT = 1;
  localparam int CTL_HALF_BIT  = 2;
  localparam int STAT_CNT_LSB  = 8;

  typedef struct packed {
    logic inhibit;
    logic hold;
    logic force_on;
    logic half_src;
    logic free_src;
  } stop_flags_t;
endpackage

// File: rtl/stopctl_hyst.sv
module stopctl_hyst #(
  parameter int LW = 10,
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] level,
  input  logic [TW-1:0] low_mark,
  input  logic [TW-1:0] margin,
  output logic          active
);
  localparam int EW = TW + 1;

  logic [EW-1:0] lvl_ext;
  logic [EW-1:0] rel_pt;
  logic          at_low;
  logic          above_rel;

  assign lvl_ext   = EW'(level);
  assign rel_pt    = EW'(low_mark) + EW'(margin);
  assign at_low    = lvl_ext <= EW'(low_mark);
  assign above_rel = lvl_ext > rel_pt;

  always_ff @(posedge clk) begin
    if (rst)
      active <= 1'b0;
    else if (active)
      active <= !above_rel;
    else
      active <= at_low;
  end
endmodule

// File: rtl/stopctl_regs.sv
module stopctl_regs
  import stopctl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 10,
  parameter int DEF_SLO = 16,
  parameter int DEF_SMG = 8,
  parameter int DEF_ILO = 8,
  parameter int DEF_IMG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  stop_flags_t       flags,
  input  logic [CNT_W-1:0]  free_cnt,
  output logic              hold,
  output logic              force_on,
  output logic              half_en,
  output logic [DATA_W-1:0] stop_lo,
  output logic [DATA_W-1:0] stop_mrg,
  output logic [DATA_W-1:0] inh_lo,
  output logic [DATA_W-1:0] inh_mrg,
  output logic [DATA_W-1:0] rdata
);
  localparam int FLAG_W = $bits(stop_flags_t);
  localparam int PAD_W  = STAT_CNT_LSB - FLAG_W;

  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] rd_mux;

  assign status_w = DATA_W'({free_cnt, PAD_W'(0), flags});

  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= 1'b1;
      force_on <= 1'b0;
      half_en  <= 1'b0;
      stop_lo  <= DATA_W'(DEF_SLO);
      stop_mrg <= DATA_W'(DEF_SMG);
      inh_lo   <= DATA_W'(DEF_ILO);
      inh_mrg  <= DATA_W'(DEF_IMG);
    end else if (we) begin
      case (stopctl_addr_e'(addr))
        ADR_CTRL: begin
          hold     <= wdata[CTL_HOLD_BIT];
          force_on <= wdata[CTL_FORCE_BIT];
          half_en  <= wdata[CTL_HALF_BIT];
        end
        ADR_STOP_LO:  stop_lo  <= wdata;
        ADR_STOP_MRG: stop_mrg <= wdata;
        ADR_INH_LO:   inh_lo   <= wdata;
        ADR_INH_MRG:  inh_mrg  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (stopctl_addr_e'(addr))
      ADR_CTRL: begin
        rd_mux[CTL_HOLD_BIT]  = hold;
        rd_mux[CTL_FORCE_BIT] = force_on;
        rd_mux[CTL_HALF_BIT]  = half_en;
      end
      ADR_STOP_LO:  rd_mux = stop_lo;
      ADR_STOP_MRG: rd_mux = stop_mrg;
      ADR_INH_LO:   rd_mux = inh_lo;
      ADR_INH_MRG:  rd_mux = inh_mrg;
      ADR_STATUS:   rd_mux = status_w;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/ingress_stop_ctrl.sv
module ingress_stop_ctrl
  import stopctl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 10,
  parameter int DEF_SLO = 16,
  parameter int DEF_SMG = 8,
  parameter int DEF_ILO = 8,
  parameter int DEF_IMG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  free_cnt,
  input  logic              infifo_half,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              link_stop,
  output logic              trig_inhibit
);
  localparam int NCMP = 2;
  localparam int CMP_STOP = 0;
  localparam int CMP_INH  = 1;

  logic              ctl_hold, ctl_force, ctl_half_en;
  logic [DATA_W-1:0] stop_lo, stop_mrg, inh_lo, inh_mrg;
  logic [DATA_W-1:0] cmp_lo  [NCMP];
  logic [DATA_W-1:0] cmp_mrg [NCMP];
  logic [NCMP-1:0]   cmp_act;
  logic              half_src;
  logic              free_src;
  logic              inh_state;
  stop_flags_t       flags;

  assign cmp_lo[CMP_STOP]  = stop_lo;
  assign cmp_mrg[CMP_STOP] = stop_mrg;
  assign cmp_lo[CMP_INH]   = inh_lo;
  assign cmp_mrg[CMP_INH]  = inh_mrg;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    stopctl_hyst #(.LW(CNT_W), .TW(DATA_W)) cmp_i (
      .clk      (clk),
      .rst      (rst),
      .level    (free_cnt),
      .low_mark (cmp_lo[g]),
      .margin   (cmp_mrg[g]),
      .active   (cmp_act[g])
    );
  end

  assign free_src  = cmp_act[CMP_STOP];
  assign inh_state = cmp_act[CMP_INH];

  always_ff @(posedge clk) begin
    if (rst) half_src <= 1'b0;
    else     half_src <= infifo_half & ctl_half_en;
  end

  assign flags = '{inhibit: inh_state, hold: ctl_hold, force_on: ctl_force,
                   half_src: half_src, free_src: free_src};

  stopctl_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W),
    .DEF_SLO(DEF_SLO), .DEF_SMG(DEF_SMG), .DEF_ILO(DEF_ILO), .DEF_IMG(DEF_IMG)
  ) regs_i (
    .clk      (clk),
    .rst      (rst),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .flags    (flags),
    .free_cnt (free_cnt),
    .hold     (ctl_hold),
    .force_on (ctl_force),
    .half_en  (ctl_half_en),
    .stop_lo  (stop_lo),
    .stop_mrg (stop_mrg),
    .inh_lo   (inh_lo),
    .inh_mrg  (inh_mrg),
    .rdata    (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      link_stop    <= 1'b1;
      trig_inhibit <= 1'b0;
    end else begin
      link_stop    <= ctl_hold | ctl_force | free_src | half_src;
      trig_inhibit <= inh_state;
    end
  end
endmodule

// File: rtl/ingress_stop_ctrl_chk.sv
module ingress_stop_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  free_cnt,
  input logic              link_stop,
  input logic              trig_inhibit,
  input logic              ctl_hold,
  input logic              ctl_force,
  input logic              half_src,
  input logic              free_src,
  input logic              inh_state,
  input logic [DATA_W-1:0] stop_lo,
  input logic [DATA_W-1:0] stop_mrg
);
  // R2
  hold_stop_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_hold |=> link_stop);
  // R6
  force_stop_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_force |=> link_stop);
  // R5
  half_stop_chk: assert property (@(posedge clk) disable iff (rst)
    half_src |=> link_stop);
  // R3
  free_stop_chk: assert property (@(posedge clk) disable iff (rst)
    free_src |=> link_stop);
  // R2
  quiet_release_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctl_hold | ctl_force | half_src | free_src) |=> !link_stop);
  // R3
  free_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(free_src) |-> ({1'b0, $past(stop_lo)} >= (DATA_W+1)'($past(free_cnt))));
  // R4
  free_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(free_src) |->
      ((DATA_W+1)'($past(free_cnt)) > ({1'b0, $past(stop_lo)} + {1'b0, $past(stop_mrg)})));
  // R7
  inh_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inh_state |=> trig_inhibit);
  // R7
  inh_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !inh_state |=> !trig_inhibit);
endmodule

bind ingress_stop_ctrl ingress_stop_ctrl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .free_cnt     (free_cnt),
  .link_stop    (link_stop),
  .trig_inhibit (trig_inhibit),
  .ctl_hold     (ctl_hold),
  .ctl_force    (ctl_force),
  .half_src     (half_src),
  .free_src     (free_src),
  .inh_state    (inh_state),
  .stop_lo      (stop_lo),
  .stop_mrg     (stop_mrg)
);

// File: tb/ingress_stop_ctrl_tb_top.sv
module ingress_stop_ctrl_tb_top;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 10;
  localparam int NVEC   = 13;
  localparam int VW     = CNT_W + 3;

  // vector: {free_cnt, infifo_half, expected link_stop, expected trig_inhibit}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {10'd100,  1'b0, 1'b0, 1'b0},
    {10'd17,   1'b0, 1'b0, 1'b0},
    {10'd16,   1'b0, 1'b1, 1'b0},
    {10'd20,   1'b0, 1'b1, 1'b0},
    {10'd24,   1'b0, 1'b1, 1'b0},
    {10'd25,   1'b0, 1'b0, 1'b0},
    {10'd8,    1'b0, 1'b1, 1'b1},
    {10'd12,   1'b0, 1'b1, 1'b1},
    {10'd13,   1'b0, 1'b1, 1'b0},
    {10'd30,   1'b1, 1'b1, 1'b0},
    {10'd30,   1'b0, 1'b0, 1'b0},
    {10'd0,    1'b0, 1'b1, 1'b1},
    {10'd1023, 1'b0, 1'b0, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CNT_W-1:0]  free_cnt = 10'd100;
  logic              infifo_half = 1'b0;
  logic              reg_we = 1'b0;
  logic [2:0]        reg_addr = 3'd0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              link_stop;
  logic              trig_inhibit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ingress_stop_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .free_cnt(free_cnt), .infifo_half(infifo_half),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .link_stop(link_stop), .trig_inhibit(trig_inhibit)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] d;
    repeat (4) @(negedge clk);
    check("R1 stop in reset", {31'b0, link_stop}, 1);
    check("R1 inhibit in reset", {31'b0, trig_inhibit}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 stop after reset", {31'b0, link_stop}, 1);
    check("R1 inhibit after reset", {31'b0, trig_inhibit}, 0);
    rd(3'd1, d); check("R1 R9 stop low default", d, 16);
    rd(3'd2, d); check("R1 R9 stop margin default", d, 8);
    rd(3'd4, d); check("R1 R9 inhibit margin default", d, 4);
    rd(3'd0, d); check("R1 R9 ctrl default", d, 1);
    rd(3'd6, d); check("R9 unused address", d, 0);
    settle();
    check("R2 hold keeps stop", {31'b0, link_stop}, 1);

    wr(3'd0, 32'h4);
    settle();
    check("R2 hold cleared", {31'b0, link_stop}, 0);

    for (int v = 0; v < NVEC; v++) begin
      free_cnt    = VEC[v][VW-1:3];
      infifo_half = VEC[v][2];
      settle();
      check($sformatf("R3 R4 R5 R7 vector %0d stop", v), {31'b0, link_stop}, {31'b0, VEC[v][1]});
      check($sformatf("R3 R4 R7 vector %0d inhibit", v), {31'b0, trig_inhibit}, {31'b0, VEC[v][0]});
    end

    wr(3'd0, 32'h6);
    settle();
    check("R6 force stop", {31'b0, link_stop}, 1);
    check("R7 inhibit ignores force", {31'b0, trig_inhibit}, 0);
    rd(3'd5, d); check("R8 status force", d, 32'h3FF04);

    wr(3'd0, 32'h0);
    infifo_half = 1'b1;
    settle();
    check("R5 half masked", {31'b0, link_stop}, 0);
    rd(3'd5, d); check("R8 status half masked", d, 32'h3FF00);
    infifo_half = 1'b0;

    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd1, d); check("R9 status write ignored lo", d, 16);
    rd(3'd0, d); check("R9 status write ignored ctrl", d, 0);
    settle();
    check("R9 status write no stop", {31'b0, link_stop}, 0);

    wr(3'd3, 32'd200);
    free_cnt = 10'd150;
    settle();
    check("R7 own threshold inhibit", {31'b0, trig_inhibit}, 1);
    check("R7 stop unaffected", {31'b0, link_stop}, 0);
    wr(3'd0, 32'h1);
    settle();
    check("R2 hold again", {31'b0, link_stop}, 1);
    check("R7 inhibit ignores hold", {31'b0, trig_inhibit}, 1);
    free_cnt = 10'd204;
    settle();
    check("R7 inhibit band edge", {31'b0, trig_inhibit}, 1);
    free_cnt = 10'd205;
    settle();
    check("R7 inhibit release", {31'b0, trig_inhibit}, 0);
    rd(3'd5, d); check("R8 status hold", d, 32'hCD08);

    finish_run();
  end
endmodule